// File: doc/BRIEF.md
# RRIP Cache Set Replacement Controller

This block keeps a 2-bit re-reference prediction for every way of one cache set and answers the question a cache controller asks on a miss: which way should be replaced. A prediction of 0 means the line is expected to be used again almost at once. A prediction of 1 means soon, 2 means far off, and 3 means distant, which marks the line as a candidate for eviction. Hits pull a line's prediction down to 0. Fills set an insertion value. A victim query returns one way: any way the tag store reports invalid, otherwise the lowest-numbered way predicted distant. When no way is distant, the whole set is aged one step per cycle until one way becomes distant. While the set is aging, the block holds its ready output low.

A single policy input chooses the insertion value. Static insertion places new lines at 2, which makes the set resistant to scans. Bimodal insertion places new lines at 3 except on rare fills chosen by an internal LFSR, which gets 2, and this makes the set resistant to thrashing. A set-dueling selector outside the block drives this input to obtain dynamic operation. Tags, data arrays and the selector are not part of the block.

Top module: `rrip_set_ctrl`

## Requirements
- R1: While reset is high, at the clock edge, every way's prediction becomes 3, ready becomes 1, victim_valid becomes 0, victim_way becomes 0 and the LFSR state becomes 0x01.
- R2: An accepted request with req_op = 0 (hit) sets the prediction of req_way to 0. policy_bimodal has no effect on a hit.
- R3: An accepted request with req_op = 1 (fill) and policy_bimodal = 0 sets the prediction of req_way to 2.
- R4: An accepted fill with policy_bimodal = 1 sets the prediction to 2 when the low 5 bits of the LFSR are all zero, and to 3 otherwise. Only such fills advance the LFSR, with next = (q >> 1) XOR (q[0] ? 0xB8 : 0) over 8 bits.
- R5: An accepted request with req_op = 2 (query) where line_valid has any zero bit returns the lowest such index. victim_valid is high on the cycle after acceptance, and no prediction changes.
- R6: A query with all lines valid and at least one prediction of 3 returns the lowest-numbered way holding 3. victim_valid is high for the single cycle after acceptance, and victim_way holds its value otherwise.
- R7: A query with all lines valid and no prediction of 3 increments every way's prediction once per cycle, starting at the accepting edge, until some way is 3. With a largest prediction m, victim_valid rises k+1 cycles after acceptance, where k = 3 - m, and ready is low for exactly those k cycles.
- R8: Requests presented while ready is low are ignored and change no prediction.
- R9: A request with req_op = 3 has no effect. A request is accepted only when req_valid and ready are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 hit, 1 fill, 2 victim query, 3 none |
| req_way | input | WAY_W | Way addressed by hit or fill |
| policy_bimodal | input | 1 | 1 selects bimodal insertion, 0 static |
| line_valid | input | WAYS | Per-way valid bits from the tag store, sampled on a query |
| ready | output | 1 | Block can accept a request |
| victim_valid | output | 1 | victim_way carries a new answer this cycle |
| victim_way | output | WAY_W | Selected victim way |

## Verification
The bench builds the block with its defaults: 4 ways, 2-bit predictions, an 8-bit LFSR and a 5-bit rare window. Four ways are enough to exercise ties between distant ways, priority of invalid ways, and aging of one, two and three steps in short sequences. Several hundred bimodal fills make the LFSR step through enough states to produce both insertion values repeatedly. A behavioural reference model follows every request and compares ready, victim_valid and victim_way on every cycle. This covers requests made while the set is aging and a long random mix of operations.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic [1:0] {
    OP_HIT   = 2'd0,
    OP_FILL  = 2'd1,
    OP_QUERY = 2'd2,
    OP_NONE  = 2'd3
  } rrip_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_AGE  = 1'b1
  } rrip_state_e;
endpackage

// File: rtl/rrip_first_one.sv
module rrip_first_one #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rrip_lfsr.sv
module rrip_lfsr #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     TAPS = 8'hB8,
  parameter logic [W-1:0]     SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)       q <= SEED;
    else if (step) q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  assign state = q;

  // R4: a Galois LFSR seeded non-zero never reaches the all-zero lock state
  p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (rst) q != '0);
endmodule

// File: rtl/rrip_set_ctrl.sv
module rrip_set_ctrl
  import rrip_pkg::*;
#(
  parameter int                WAYS      = 4,
  parameter int                RRPV_W    = 2,
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  parameter int                RARE_BITS = 5,
  localparam int               WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [WAY_W-1:0] req_way,
  input  logic             policy_bimodal,
  input  logic [WAYS-1:0]  line_valid,
  output logic             ready,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [RRPV_W-1:0] PRED_DISTANT = {RRPV_W{1'b1}};
  localparam logic [RRPV_W-1:0] PRED_LONG    = PRED_DISTANT - 1'b1;

  logic [RRPV_W-1:0] pred_q [WAYS];
  rrip_state_e       state_q;
  logic              ready_q;
  logic              vv_q;
  logic [WAY_W-1:0]  vw_q;
  logic              from_invalid_q;

  logic [WAYS-1:0]   distant_vec;
  logic              dist_found, inv_found;
  logic [WAY_W-1:0]  dist_idx, inv_idx;
  logic [LFSR_W-1:0] lfsr_state;
  logic              accept, lfsr_step, rare_hit;
  logic [RRPV_W-1:0] ins_val;

  always_comb begin
    for (int i = 0; i < WAYS; i++) distant_vec[i] = (pred_q[i] == PRED_DISTANT);
  end

  rrip_first_one #(.N(WAYS), .IW(WAY_W)) u_pick_distant (
    .vec(distant_vec), .found(dist_found), .idx(dist_idx));

  rrip_first_one #(.N(WAYS), .IW(WAY_W)) u_pick_invalid (
    .vec(~line_valid), .found(inv_found), .idx(inv_idx));

  assign accept    = req_valid && ready_q;
  assign lfsr_step = accept && (req_op == OP_FILL) && policy_bimodal;

  rrip_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .step(lfsr_step), .state(lfsr_state));

  assign rare_hit = (lfsr_state[RARE_BITS-1:0] == '0);
  assign ins_val  = (policy_bimodal && !rare_hit) ? PRED_DISTANT : PRED_LONG;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) pred_q[i] <= PRED_DISTANT;
      state_q        <= ST_IDLE;
      ready_q        <= 1'b1;
      vv_q           <= 1'b0;
      vw_q           <= '0;
      from_invalid_q <= 1'b0;
    end else begin
      vv_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            case (req_op)
              OP_HIT:  pred_q[req_way] <= '0;
              OP_FILL: pred_q[req_way] <= ins_val;
              OP_QUERY: begin
                if (inv_found) begin
                  vv_q           <= 1'b1;
                  vw_q           <= inv_idx;
                  from_invalid_q <= 1'b1;
                end else if (dist_found) begin
                  vv_q           <= 1'b1;
                  vw_q           <= dist_idx;
                  from_invalid_q <= 1'b0;
                end else begin
                  for (int i = 0; i < WAYS; i++) pred_q[i] <= pred_q[i] + 1'b1;
                  state_q <= ST_AGE;
                  ready_q <= 1'b0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_AGE: begin
          if (dist_found) begin
            vv_q           <= 1'b1;
            vw_q           <= dist_idx;
            from_invalid_q <= 1'b0;
            state_q        <= ST_IDLE;
            ready_q        <= 1'b1;
          end else begin
            for (int i = 0; i < WAYS; i++) pred_q[i] <= pred_q[i] + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready        = ready_q;
  assign victim_valid = vv_q;
  assign victim_way   = vw_q;

  // R2: a hit leaves its way at the nearest prediction
  p_hit_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && req_op == OP_HIT) |=> pred_q[$past(req_way)] == '0);

  // R3: a static fill lands one below distant
  p_fill_static_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && req_op == OP_FILL && !policy_bimodal) |=> pred_q[$past(req_way)] == PRED_LONG);

  // R4: a bimodal fill lands at far or distant
  p_fill_bimodal_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && req_op == OP_FILL && policy_bimodal) |=> pred_q[$past(req_way)] >= PRED_LONG);

  // R6: a victim taken from the prediction search is distant
  p_victim_distant_r6: assert property (@(posedge clk) disable iff (rst)
    (vv_q && !from_invalid_q) |-> pred_q[vw_q] == PRED_DISTANT);

  // R7: ready is low for the whole aging walk
  p_ready_low_age_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AGE) |-> !ready_q);

  // R7: each aging cycle without a distant way advances the predictions by one
  p_age_step_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AGE && !dist_found) |=> pred_q[0] == RRPV_W'($past(pred_q[0]) + 1'b1));

  // R8: nothing but aging touches the predictions while busy
  p_busy_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AGE && dist_found) |=> $stable(pred_q[0]));
endmodule

// File: tb/tb_rrip_set_ctrl.sv
module tb_rrip_set_ctrl;
  localparam int WAYS = 4;
  localparam int WW   = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [WW-1:0] req_way;
  logic          policy_bimodal;
  logic [WAYS-1:0] line_valid;
  logic          ready, victim_valid;
  logic [WW-1:0] victim_way;

  always #4 clk = ~clk;

  rrip_set_ctrl #(.WAYS(WAYS), .RRPV_W(2), .LFSR_W(8), .LFSR_TAPS(8'hB8),
                  .LFSR_SEED(8'h01), .RARE_BITS(5)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_way(req_way), .policy_bimodal(policy_bimodal), .line_valid(line_valid),
    .ready(ready), .victim_valid(victim_valid), .victim_way(victim_way));

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";

  int rr [WAYS];
  int lf;
  int m_busy;
  bit m_ready, m_vv;
  int m_vw;

  function automatic int lfsr_next(int q);
    return (q >> 1) ^ (((q & 1) != 0) ? 'hB8 : 0);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < WAYS; i++) rr[i] = 3;
    lf = 1; m_busy = 0; m_ready = 1; m_vv = 0; m_vw = 0;
  endtask

  function automatic int lowest_three();
    for (int i = 0; i < WAYS; i++) if (rr[i] == 3) return i;
    return -1;
  endfunction

  task automatic model_step(bit v, int op, int way, bit bim, logic [WAYS-1:0] lv);
    int d;
    int inv;
    m_vv = 0;
    if (m_busy == 0) begin
      if (v) begin
        if (op == 0) rr[way] = 0;
        else if (op == 1) begin
          if (bim) begin
            rr[way] = ((lf & 31) == 0) ? 2 : 3;
            lf = lfsr_next(lf);
          end else rr[way] = 2;
        end else if (op == 2) begin
          inv = -1;
          for (int i = WAYS - 1; i >= 0; i--) if (!lv[i]) inv = i;
          d = lowest_three();
          if (inv >= 0) begin m_vv = 1; m_vw = inv; end
          else if (d >= 0) begin m_vv = 1; m_vw = d; end
          else begin
            for (int i = 0; i < WAYS; i++) rr[i]++;
            m_busy = 1; m_ready = 0;
          end
        end
      end
    end else begin
      d = lowest_three();
      if (d >= 0) begin m_vv = 1; m_vw = d; m_busy = 0; m_ready = 1; end
      else for (int i = 0; i < WAYS; i++) rr[i]++;
    end
  endtask

  task automatic compare();
    checks++;
    if (ready !== m_ready || victim_valid !== m_vv || victim_way !== WW'(m_vw)) begin
      fails++;
      $display("FAIL %s ready/vv/way actual %b/%b/%0d expected %b/%b/%0d",
               cur_req, ready, victim_valid, victim_way, m_ready, m_vv, m_vw);
    end
  endtask

  task automatic step(bit v, int op, int way, bit bim, logic [WAYS-1:0] lv);
    req_valid = v; req_op = 2'(op); req_way = WW'(way);
    policy_bimodal = bim; line_valid = lv;
    model_step(v, op, way, bim, lv);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3, 0, 0, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_op = 0; req_way = 0;
    policy_bimodal = 0; line_valid = 4'hF;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; compare();
    idle(1);

    cur_req = "R5";
    step(1, 2, 0, 0, 4'b1011);
    step(1, 2, 0, 0, 4'b0110);
    idle(1);

    cur_req = "R6";
    step(1, 2, 0, 0, 4'hF);
    idle(2);

    cur_req = "R2";
    step(1, 0, 0, 1, 4'hF);
    step(1, 2, 0, 0, 4'hF);
    idle(1);

    cur_req = "R3";
    for (int w = 1; w < WAYS; w++) step(1, 1, w, 0, 4'hF);
    step(1, 2, 0, 0, 4'hF);
    idle(3);

    cur_req = "R7";
    for (int w = 0; w < WAYS; w++) step(1, 0, w, 0, 4'hF);
    step(1, 2, 0, 0, 4'hF);
    cur_req = "R8";
    step(1, 0, 0, 0, 4'hF);
    step(1, 1, 1, 1, 4'hF);
    step(1, 2, 2, 0, 4'b0000);
    idle(2);
    step(1, 2, 0, 0, 4'hF);
    idle(1);

    cur_req = "R9";
    for (int w = 0; w < WAYS; w++) step(1, 0, w, 0, 4'hF);
    step(1, 1, 2, 0, 4'hF);
    step(1, 3, 2, 0, 4'hF);
    step(0, 0, 2, 0, 4'hF);
    step(1, 2, 0, 0, 4'hF);
    idle(3);

    cur_req = "R4";
    for (int n = 0; n < 300; n++) begin
      for (int w = 0; w < WAYS - 1; w++) step(1, 0, w, 0, 4'hF);
      step(1, 1, WAYS - 1, 1, 4'hF);
      step(1, 2, 0, 0, 4'hF);
      idle(2);
    end

    cur_req = "mixed R2 R3 R4 R5 R6 R7 R8 R9";
    for (int n = 0; n < 3000; n++) begin
      logic [WAYS-1:0] lv;
      lv = (($urandom % 8) == 0) ? WAYS'($urandom) : 4'hF;
      step(bit'($urandom % 4 != 0), int'($urandom % 4), int'($urandom % WAYS),
           bit'($urandom % 2), lv);
    end
    idle(5);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule